// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures the response of a network to an on-chip sinusoidal excitation. It correlates the returned signal against one test phasor only: the one at the frequency the excitation generator is producing at that moment. It does not take a frequency setting of its own. It reads the generator's live 27-bit phase word and uses the six most significant bits of that word to index a 64-point cosine/sine coefficient table. The analysis bin therefore always follows the excitation, and the result is a single-point DFT.

The block divides the system clock by 16 to produce the ADC sample strobe. After a start pulse it takes exactly 1024 signed 12-bit samples. Each sample is multiplied by the cosine coefficient for the phase captured on the same clock edge, and the products are summed into the real result. Each sample is also multiplied by the sine coefficient for that phase, and those products are subtracted into the imaginary result. When the last product has been added, a done flag pulses for one cycle. The two signed sums then hold until the next start. Magnitude and phase are computed further downstream from these two sums.

Top module: `sbdft_correlator`

## Requirements
- R1: `sampleStrobe` is high for exactly one cycle in every 16. The divider restarts on the edge that samples `start`, so the first strobe after a start is high during the 16th cycle after that edge.
- R2: A clock edge that samples `start` high sets both results to zero and `done` low in the next cycle, and begins a new measurement.
- R3: Samples presented before the first start, or after a measurement has completed, do not change the results and raise no `done`. After reset both results are zero and `done` is low.
- R4: A measurement uses exactly the first 1024 strobes after the start edge. `done` is high for a single cycle: the cycle that begins 16·1024+2 rising edges after the edge that sampled `start`.
- R5: `resultRe` equals the sum over the 1024 samples of x·C(i). C(i) = S((i+16) mod 64), S(i) = round(32767·sin(2π·i/64)), and x is the sample as a signed two's-complement value.
- R6: `resultIm` equals minus the sum over the 1024 samples of x·S(i).
- R7: The table index i is bits 26:21 of `excPhase`, sampled on the same clock edge as the `adcData` value it multiplies.
- R8: A constant input gives exactly zero in both results when the 1024 samples span an odd whole number of excitation cycles.
- R9: From the cycle in which `done` is high until the next start, both results stay unchanged, whatever the inputs do.
- R10: A start issued during a measurement discards the partial sums. The results then cover only the 1024 samples that follow the new start.
- R11: The results are 39 bits wide. A run of 1024 samples of -2048 at index 32 gives exactly 1024·2048·32767 in `resultRe` and 0 in `resultIm`, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the excitation generator's clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse: clear the sums and begin a 1024-sample measurement |
| excPhase | input | 27 | Live phase word of the excitation generator |
| adcData | input | 12 | Signed ADC response sample |
| sampleStrobe | output | 1 | Sample strobe for the ADC, system clock divided by 16 |
| done | output | 1 | One-cycle pulse when both results are complete |
| resultRe | output | 39 | Signed in-phase (real) correlation sum |
| resultIm | output | 39 | Signed quadrature (imaginary) correlation sum |

## Verification
Two integer-cycle tones with a dc offset are applied, one at 5 cycles and one at 37 cycles per block. They differ in starting phase and in the low phase bits, so an error in the index bits or in the phase-to-sample alignment shows up as a mismatch against the bench's own correlation. A tone that is not a whole number of cycles per block checks that leakage is reproduced exactly rather than hidden by symmetry. A pure dc input at an odd cycle count must give exact zeros, which exposes a wrong table sign or a wrong quadrant fold. Further runs cover a restart part way through a measurement and a constant full-scale input; these separate stale-sum and overflow faults from faults in the correlation itself.

// File: rtl/sbdft_pkg.sv
package sbdft_pkg;

  localparam int COEF_W = 16;
  localparam int LUT_AW = 6;

  typedef logic signed [COEF_W-1:0] coef_t;

  typedef struct packed {
    logic clearAll;
    logic capture;
    logic lastCapture;
  } dftCtl_t;

  // One quarter of the wave, 17 points: round(32767 * sin(k * pi / 32)).
  function automatic coef_t quarterSin(input logic [4:0] k);
    case (k)
      5'd0:    return 16'sd0;
      5'd1:    return 16'sd3212;
      5'd2:    return 16'sd6393;
      5'd3:    return 16'sd9512;
      5'd4:    return 16'sd12539;
      5'd5:    return 16'sd15446;
      5'd6:    return 16'sd18204;
      5'd7:    return 16'sd20787;
      5'd8:    return 16'sd23170;
      5'd9:    return 16'sd25329;
      5'd10:   return 16'sd27245;
      5'd11:   return 16'sd28898;
      5'd12:   return 16'sd30273;
      5'd13:   return 16'sd31356;
      5'd14:   return 16'sd32137;
      5'd15:   return 16'sd32609;
      default: return 16'sd32767;
    endcase
  endfunction

  // Full 64-point sine, folded from the quarter by quadrant.
  function automatic coef_t waveSin(input logic [LUT_AW-1:0] idx);
    logic [4:0] pos;
    pos = {1'b0, idx[3:0]};
    case (idx[5:4])
      2'd0:    return quarterSin(pos);
      2'd1:    return quarterSin(5'd16 - pos);
      2'd2:    return -quarterSin(pos);
      default: return -quarterSin(5'd16 - pos);
    endcase
  endfunction

  function automatic coef_t waveCos(input logic [LUT_AW-1:0] idx);
    return waveSin(idx + LUT_AW'(16));
  endfunction

endpackage

// File: rtl/sbdft_ctrl.sv
module sbdft_ctrl
  import sbdft_pkg::*;
#(
  parameter int CLK_DIV     = 16,
  parameter int NUM_SAMPLES = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output logic    sampleStrobe,
  output dftCtl_t ctl
);

  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int CNT_W = $clog2(NUM_SAMPLES);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] sampleCnt;
  logic             collecting;

  always_comb begin
    sampleStrobe    = (divCnt == DIV_W'(CLK_DIV - 1));
    ctl.clearAll    = start;
    ctl.capture     = collecting & sampleStrobe & ~start;
    ctl.lastCapture = ctl.capture & (sampleCnt == CNT_W'(NUM_SAMPLES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      sampleCnt  <= '0;
      collecting <= 1'b0;
    end else if (start) begin
      divCnt     <= '0;
      sampleCnt  <= '0;
      collecting <= 1'b1;
    end else begin
      divCnt <= sampleStrobe ? '0 : divCnt + 1'b1;
      if (ctl.capture) begin
        sampleCnt <= sampleCnt + 1'b1;
        if (ctl.lastCapture) collecting <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sbdft_datapath.sv
module sbdft_datapath
  import sbdft_pkg::*;
#(
  parameter int PHASE_W  = 27,
  parameter int SAMPLE_W = 12,
  parameter int RES_W    = 39
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dftCtl_t                    ctl,
  input  logic [PHASE_W-1:0]         excPhase,
  input  logic signed [SAMPLE_W-1:0] adcData,
  output logic                       done,
  output logic signed [RES_W-1:0]    resultRe,
  output logic signed [RES_W-1:0]    resultIm
);

  localparam int PROD_W    = SAMPLE_W + COEF_W;
  localparam int NUM_LANES = 2;

  logic [LUT_AW-1:0]          lutIdx;
  logic signed [SAMPLE_W-1:0] smpReg;
  logic                       capValid, capLast;
  logic                       prodValid, prodLast;
  logic signed [RES_W-1:0]    accArr [NUM_LANES];

  assign lutIdx = excPhase[PHASE_W-1 -: LUT_AW];

  // Stage control: capture -> multiply -> accumulate.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpReg    <= '0;
      capValid  <= 1'b0;
      capLast   <= 1'b0;
      prodValid <= 1'b0;
      prodLast  <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (ctl.capture) smpReg <= adcData;
      capValid  <= ctl.capture & ~ctl.clearAll;
      capLast   <= ctl.lastCapture;
      prodValid <= capValid & ~ctl.clearAll;
      prodLast  <= capLast;
      done      <= prodValid & prodLast & ~ctl.clearAll;
    end
  end

  // Lane 0 correlates with cosine and adds; lane 1 with sine and subtracts.
  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : gLane
    coef_t                    coefNow;
    coef_t                    coefReg;
    logic signed [PROD_W-1:0] prodReg;

    if (ln == 0) begin : gCos
      assign coefNow = waveCos(lutIdx);
    end else begin : gSin
      assign coefNow = waveSin(lutIdx);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coefReg <= '0;
        prodReg <= '0;
      end else begin
        if (ctl.capture) coefReg <= coefNow;
        prodReg <= PROD_W'(smpReg) * PROD_W'(coefReg);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accArr[ln] <= '0;
      end else if (ctl.clearAll) begin
        accArr[ln] <= '0;
      end else if (prodValid) begin
        if (ln == 0) accArr[ln] <= accArr[ln] + RES_W'(prodReg);
        else         accArr[ln] <= accArr[ln] - RES_W'(prodReg);
      end
    end
  end

  assign resultRe = accArr[0];
  assign resultIm = accArr[1];

endmodule

// File: rtl/sbdft_correlator.sv
module sbdft_correlator
  import sbdft_pkg::*;
#(
  parameter int PHASE_W     = 27,
  parameter int SAMPLE_W    = 12,
  parameter int NUM_SAMPLES = 1024,
  parameter int CLK_DIV     = 16,
  localparam int RES_W      = SAMPLE_W + COEF_W + $clog2(NUM_SAMPLES) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [PHASE_W-1:0]         excPhase,
  input  logic signed [SAMPLE_W-1:0] adcData,
  output logic                       sampleStrobe,
  output logic                       done,
  output logic signed [RES_W-1:0]    resultRe,
  output logic signed [RES_W-1:0]    resultIm
);

  dftCtl_t ctl;

  sbdft_ctrl #(
    .CLK_DIV    (CLK_DIV),
    .NUM_SAMPLES(NUM_SAMPLES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .sampleStrobe(sampleStrobe),
    .ctl         (ctl)
  );

  sbdft_datapath #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W),
    .RES_W   (RES_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .excPhase(excPhase),
    .adcData (adcData),
    .done    (done),
    .resultRe(resultRe),
    .resultIm(resultIm)
  );

endmodule

// File: rtl/sbdft_checker.sv
module sbdft_checker #(
  parameter int CLK_DIV     = 16,
  parameter int NUM_SAMPLES = 1024,
  parameter int RES_W       = 39
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    sampleStrobe,
  input logic                    done,
  input logic signed [RES_W-1:0] resultRe,
  input logic signed [RES_W-1:0] resultIm
);

  localparam int GAP_W = $clog2(CLK_DIV) + 1;
  localparam int CNT_W = $clog2(NUM_SAMPLES) + 1;

  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] strobesSeen;
  logic             armed;
  logic             held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap         <= '0;
      strobesSeen <= '0;
      armed       <= 1'b0;
      held        <= 1'b0;
    end else begin
      gap <= (start || sampleStrobe) ? '0 : gap + 1'b1;
      if (start) begin
        strobesSeen <= '0;
        armed       <= 1'b1;
        held        <= 1'b0;
      end else begin
        if (armed && sampleStrobe && strobesSeen != CNT_W'(NUM_SAMPLES))
          strobesSeen <= strobesSeen + 1'b1;
        if (done) held <= 1'b1;
      end
    end
  end

  // R1
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe == (gap == GAP_W'(CLK_DIV - 1)));

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && resultRe == '0 && resultIm == '0));

  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (armed && strobesSeen == CNT_W'(NUM_SAMPLES)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((held || done) && !start) |=> ($stable(resultRe) && $stable(resultIm)));

endmodule

bind sbdft_correlator sbdft_checker #(
  .CLK_DIV    (CLK_DIV),
  .NUM_SAMPLES(NUM_SAMPLES),
  .RES_W      (RES_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .sampleStrobe(sampleStrobe),
  .done        (done),
  .resultRe    (resultRe),
  .resultIm    (resultIm)
);

// File: tb/tb_sbdft_correlator.sv
module tb_sbdft_correlator;

  localparam int N     = 1024;
  localparam int DIV   = 16;
  localparam int RES_W = 39;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rstN, start;
  logic [26:0]             excPhase;
  logic signed [11:0]      adcData;
  logic                    sampleStrobe, done;
  logic signed [RES_W-1:0] resultRe, resultIm;

  sbdft_correlator dut (
    .clk(clk), .rstN(rstN), .start(start), .excPhase(excPhase),
    .adcData(adcData), .sampleStrobe(sampleStrobe), .done(done),
    .resultRe(resultRe), .resultIm(resultIm)
  );

  int     checks = 0, fails = 0, cyc = 0;
  bit     finished = 0;
  logic [26:0] phaseAcc = '0;
  int     fw = 0, ampl = 0, dcOff = 0, sh = 0;
  longint refRe = 0, refIm = 0;
  int     refCnt = 0;
  bit     armed = 0;
  int     startTick = -1, doneTick = -1, doneCount = 0;
  int     lastStrobe = -1, strobeGood = 0, strobeBad = 0;

  function automatic int tabSin(input int i);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(i % 64) / 64.0);
    return int'($floor(v + 0.5));
  endfunction

  function automatic int tabCos(input int i);
    return tabSin(i + 16);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    int idx, x;
    @(negedge clk);
    cyc++;
    phaseAcc = phaseAcc + 27'(fw);
    idx = int'(phaseAcc[26:21]);
    x = dcOff + (ampl * tabSin((idx + sh) % 64)) / 32768;
    excPhase = phaseAcc;
    adcData  = 12'(x);
    if (done) begin
      doneCount++;
      doneTick = cyc;
    end
    if (sampleStrobe) begin
      if (lastStrobe >= 0 && lastStrobe > startTick) begin
        if (cyc - lastStrobe == DIV) strobeGood++; else strobeBad++;
      end
      lastStrobe = cyc;
      if (armed && refCnt < N) begin
        refRe += longint'(x) * longint'(tabCos(idx));
        refIm -= longint'(x) * longint'(tabSin(idx));
        refCnt++;
      end
    end
  endtask

  task automatic startMeas();
    tick();
    start = 1'b1;
    startTick = cyc;
    armed = 0;
    refRe = 0;
    refIm = 0;
    refCnt = 0;
    tick();
    start = 1'b0;
    armed = 1;
  endtask

  task automatic finishMeas(input string tag);
    int n = 0;
    int d0 = doneCount;
    while (doneCount == d0 && n < 20000) begin
      tick();
      n++;
    end
    check(doneCount == d0 + 1, {"R4 done seen ", tag}, doneCount - d0, 1);
    check(doneTick - startTick == 16 * N + 3, {"R4 done timing ", tag},
          doneTick - startTick, 16 * N + 3);
    check(resultRe == refRe, {"R5 real ", tag}, resultRe, refRe);
    check(resultIm == refIm, {"R6 imag ", tag}, resultIm, refIm);
    tick();
    check(done == 1'b0, {"R4 single-cycle done ", tag}, done, 0);
  endtask

  initial begin
    #(LIMIT * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    longint saveRe, saveIm;
    int d0;
    rstN = 1'b0;
    start = 1'b0;
    excPhase = '0;
    adcData = '0;
    repeat (4) tick();
    rstN = 1'b1;
    tick();
    check(done == 1'b0, "R3 reset done", done, 0);
    check(resultRe == 0, "R3 reset real", resultRe, 0);
    check(resultIm == 0, "R3 reset imag", resultIm, 0);

    // Signal present but no start: nothing accumulates.
    fw = 5 * 8192; ampl = 1800; dcOff = 100; sh = 0;
    repeat (300) tick();
    check(resultRe == 0 && resultIm == 0, "R3 no start", resultRe, 0);
    check(doneCount == 0, "R3 no done before start", doneCount, 0);
    check(strobeBad == 0 && strobeGood > 10, "R1 strobe spacing idle", strobeBad, 0);

    // Integer-cycle tone, 5 cycles, dc offset.
    phaseAcc = '0; fw = 5 * 8192; ampl = 1500; dcOff = 300; sh = 3;
    startMeas();
    finishMeas("tone5");

    // Hold after completion while inputs keep changing (R9, R3).
    saveRe = resultRe; saveIm = resultIm; d0 = doneCount;
    ampl = 1900; dcOff = -50;
    repeat (600) tick();
    check(resultRe == saveRe, "R9 hold real", resultRe, saveRe);
    check(resultIm == saveIm, "R9 hold imag", resultIm, saveIm);
    check(doneCount == d0, "R3 no done after completion", doneCount, d0);

    // New start clears, then a 37-cycle tone with odd phase bits (R2, R7).
    phaseAcc = 27'h1234567; fw = 37 * 8192; ampl = 1700; dcOff = -300; sh = 11;
    startMeas();
    check(resultRe == 0 && resultIm == 0 && done == 1'b0, "R2 clear on start", resultRe, 0);
    finishMeas("tone37 R7");

    // Pure dc over an odd whole number of cycles (R8).
    phaseAcc = 27'h0ABCDEF; fw = 3 * 8192; ampl = 0; dcOff = -777; sh = 0;
    startMeas();
    finishMeas("dc");
    check(resultRe == 0, "R8 dc real zero", resultRe, 0);
    check(resultIm == 0, "R8 dc imag zero", resultIm, 0);

    // Non-integer cycle count: leakage reproduced exactly.
    phaseAcc = '0; fw = 5 * 8192 + 3001; ampl = 1200; dcOff = 600; sh = 0;
    startMeas();
    finishMeas("leak");

    // Restart mid-measurement (R10).
    phaseAcc = '0; fw = 7 * 8192; ampl = 2000; dcOff = 0; sh = 5;
    startMeas();
    repeat (5000) tick();
    fw = 9 * 8192; ampl = 1000; dcOff = 400; sh = 20;
    startMeas();
    finishMeas("R10 restart");

    // Full scale constant at index 32 (R11).
    phaseAcc = 27'h4000000; fw = 0; ampl = 0; dcOff = -2048; sh = 0;
    startMeas();
    finishMeas("fullscale");
    check(resultRe == 64'sd68717379584, "R11 full-scale real", resultRe, 64'sd68717379584);
    check(resultIm == 0, "R11 full-scale imag", resultIm, 0);

    check(strobeBad == 0, "R1 strobe spacing overall", strobeBad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule